// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level translation table from memory. Three mapping sizes are supported: 1 MB sections described directly by a first-level word, and 64 KB or 4 KB pages described by a word in a second-level table. The two low bits of each table word select its kind. A walk takes one memory read for a section or a first-level fault, and two reads for any other result.

A client presents a virtual address with `req_valid` while `busy` is low, and the table base on `tbl_base` is captured at that moment. The walker issues word reads through a valid/ready request channel. Each read is answered by a single response strobe carrying the data word. A walk ends with a one-cycle `done` strobe and the assembled physical address, or with a one-cycle `fault` strobe. A fault reports the virtual address, the table base and the table level that failed.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are all low.
- R2: A request is taken in a cycle where `req_valid` is high and `busy` is low. `busy` then stays high until the cycle in which `done` or `fault` pulses, and `req_valid` has no effect while `busy` is high.
- R3: The first read goes to `tbl_base + 4*va[31:20]`, using the base value captured when the request was taken.
- R4: A first-level word with low bits 2'b10 is a section, 2'b01 points to a second-level table, and 2'b00 or 2'b11 is a fault.
- R5: A section result is `{entry[31:20], va[19:0]}` and is produced after exactly one read.
- R6: The second read goes to `{entry1[31:10], 10'b0} + 4*va[19:12]`.
- R7: A second-level word with low bits 2'b00 is a fault, 2'b01 is a 64 KB page, and any word with bit 1 set is a 4 KB page.
- R8: A 64 KB page result is `{entry[31:16], va[15:0]}`. Every one of the sixteen slots that hold copies of the word gives the same page.
- R9: A 4 KB page result is `{entry[31:12], va[11:0]}`.
- R10: A fault pulses `fault` for one cycle and never at the same time as `done`. It reports `fault_va` as the request address and `fault_base` as the captured base, and sets `fault_level` to 0 for a first-level fault and 1 for a second-level fault.
- R11: A read request holds its address stable until it is accepted. There is never more than one read outstanding, and a walk makes at most two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Byte address of the first-level table |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle strobe: `pa` is valid |
| pa | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle strobe: the walk faulted |
| fault_level | output | 1 | 0 for a first-level fault, 1 for a second-level fault |
| fault_va | output | 32 | Virtual address that faulted |
| fault_base | output | 32 | Table base in use when the fault occurred |

## Verification
The checker watches several properties on every cycle. It covers the read channel discipline: address held under back-pressure, one read in flight, and no more than two reads per walk. It also covers the exclusive single-cycle result strobes, the link between `busy` and the end of a walk, the fault level against the number of reads made, and the section address assembled from the first word read. The bench scenarios are the only place where the page-sized results, the second-level address arithmetic, the decoding of each low-bit code and the fact that all sixteen large-page copies agree can be seen. The same holds for the case where a request is ignored while busy. For these, the bench compares every result and read address against a reference walk of its own memory image.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

   // Meaning of a table word once its level and low bits are known.
   typedef enum logic [2:0] {
      K_FAULT = 3'd0,
      K_NEXT  = 3'd1,
      K_SECT  = 3'd2,
      K_LARGE = 3'd3,
      K_SMALL = 3'd4
   } ent_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_ASK  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_ASK  = 3'd3,
      ST_L2_WAIT = 3'd4
   } walk_state_e;

endpackage

// File: rtl/xlat_entry_decode.sv
// Classifies a table word from its two low bits; LEVEL picks the code set.
module xlat_entry_decode
   import xlat_walker_pkg::*;
#(
   parameter int LEVEL = 1
) (
   input  logic [1:0] type_bits,
   output ent_kind_e  kind
);

   generate
      if (LEVEL == 1) begin : g_first
         always_comb begin
            unique case (type_bits)
               2'b01:   kind = K_NEXT;
               2'b10:   kind = K_SECT;
               default: kind = K_FAULT;
            endcase
         end
      end else if (LEVEL == 2) begin : g_second
         always_comb begin
            if (type_bits[1])      kind = K_SMALL;
            else if (type_bits[0]) kind = K_LARGE;
            else                   kind = K_FAULT;
         end
      end else begin : g_bad
         $error("xlat_entry_decode: LEVEL must be 1 or 2");
         assign kind = K_FAULT;
      end
   endgenerate

endmodule

// File: rtl/xlat_addr_gen.sv
// Forms the byte addresses of the first- and second-level table words.
module xlat_addr_gen #(
   parameter int ADDR_W        = 32,
   parameter int SECT_SHIFT    = 20,
   parameter int SPAGE_SHIFT   = 12,
   parameter int L2_BASE_SHIFT = 10,
   parameter int WORD_SHIFT    = 2,
   parameter bit JOIN_ALIGNED  = 1'b0
) (
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [ADDR_W-1:0] va_new,
   input  logic [ADDR_W-1:0] va_held,
   input  logic [ADDR_W-1:0] l1_entry,
   output logic [ADDR_W-1:0] l1_addr,
   output logic [ADDR_W-1:0] l2_addr
);

   localparam int L1_IDX_W = ADDR_W - SECT_SHIFT;
   localparam int L2_IDX_W = SECT_SHIFT - SPAGE_SHIFT;
   localparam int L1_PAD   = ADDR_W - L1_IDX_W - WORD_SHIFT;
   localparam int L2_PAD   = ADDR_W - L2_IDX_W - WORD_SHIFT;
   localparam logic [ADDR_W-1:0] L2_BASE_MASK = ~((ADDR_W'(1) << L2_BASE_SHIFT) - ADDR_W'(1));

   logic [ADDR_W-1:0] l1_off;
   logic [ADDR_W-1:0] l2_off;
   logic [ADDR_W-1:0] l2_base;

   assign l1_off  = {{L1_PAD{1'b0}}, va_new[ADDR_W-1:SECT_SHIFT], {WORD_SHIFT{1'b0}}};
   assign l2_off  = {{L2_PAD{1'b0}}, va_held[SECT_SHIFT-1:SPAGE_SHIFT], {WORD_SHIFT{1'b0}}};
   assign l2_base = l1_entry & L2_BASE_MASK;

   generate
      if (JOIN_ALIGNED) begin : g_join
         // Bases known to be table-size aligned: OR in the index, no carry chain.
         assign l1_addr = tbl_base | l1_off;
         assign l2_addr = l2_base | l2_off;
      end else begin : g_add
         assign l1_addr = tbl_base + l1_off;
         assign l2_addr = l2_base + l2_off;
      end
   endgenerate

endmodule

// File: rtl/xlat_pa_build.sv
// Joins the frame bits of the final table word with the page offset.
module xlat_pa_build
   import xlat_walker_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SECT_SHIFT  = 20,
   parameter int LPAGE_SHIFT = 16,
   parameter int SPAGE_SHIFT = 12
) (
   input  ent_kind_e                    kind,
   input  logic [ADDR_W-1:SPAGE_SHIFT]  frame,
   input  logic [SECT_SHIFT-1:0]        va_off,
   output logic [ADDR_W-1:0]            pa
);

   always_comb begin
      unique case (kind)
         K_SECT:  pa = {frame[ADDR_W-1:SECT_SHIFT],  va_off[SECT_SHIFT-1:0]};
         K_LARGE: pa = {frame[ADDR_W-1:LPAGE_SHIFT], va_off[LPAGE_SHIFT-1:0]};
         K_SMALL: pa = {frame[ADDR_W-1:SPAGE_SHIFT], va_off[SPAGE_SHIFT-1:0]};
         default: pa = '0;
      endcase
   end

endmodule

// File: rtl/xlat_walk_ctrl.sv
// Sequencer: request capture, the read handshakes and the result registers.
module xlat_walk_ctrl
   import xlat_walker_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  ent_kind_e         l1_kind,
   input  ent_kind_e         l2_kind,
   input  logic [ADDR_W-1:0] l1_addr,
   input  logic [ADDR_W-1:0] l2_addr,
   input  logic [ADDR_W-1:0] pa_next,
   output logic              second_level,
   output logic [ADDR_W-1:0] va_q,
   output logic              busy,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic              done,
   output logic [ADDR_W-1:0] pa,
   output logic              fault,
   output logic              fault_level,
   output logic [ADDR_W-1:0] fault_va,
   output logic [ADDR_W-1:0] fault_base
);

   walk_state_e       state;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         va_q        <= '0;
         base_q      <= '0;
         addr_q      <= '0;
         done        <= 1'b0;
         pa          <= '0;
         fault       <= 1'b0;
         fault_level <= 1'b0;
         fault_va    <= '0;
         fault_base  <= '0;
      end else begin
         done  <= 1'b0;
         fault <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_va;
                  base_q <= tbl_base;
                  addr_q <= l1_addr;
                  state  <= ST_L1_ASK;
               end
            end
            ST_L1_ASK: begin
               if (mem_req_ready) state <= ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
               if (mem_rsp_valid) begin
                  unique case (l1_kind)
                     K_NEXT: begin
                        addr_q <= l2_addr;
                        state  <= ST_L2_ASK;
                     end
                     K_SECT: begin
                        pa    <= pa_next;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                     end
                     default: begin
                        fault       <= 1'b1;
                        fault_level <= 1'b0;
                        fault_va    <= va_q;
                        fault_base  <= base_q;
                        state       <= ST_IDLE;
                     end
                  endcase
               end
            end
            ST_L2_ASK: begin
               if (mem_req_ready) state <= ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
               if (mem_rsp_valid) begin
                  if (l2_kind == K_LARGE || l2_kind == K_SMALL) begin
                     pa   <= pa_next;
                     done <= 1'b1;
                  end else begin
                     fault       <= 1'b1;
                     fault_level <= 1'b1;
                     fault_va    <= va_q;
                     fault_base  <= base_q;
                  end
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state != ST_IDLE);
   assign mem_req_valid = (state == ST_L1_ASK) || (state == ST_L2_ASK);
   assign mem_req_addr  = addr_q;
   assign second_level  = (state == ST_L2_WAIT);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_walker_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int SECT_SHIFT    = 20,
   parameter int LPAGE_SHIFT   = 16,
   parameter int SPAGE_SHIFT   = 12,
   parameter int L2_BASE_SHIFT = 10,
   parameter int WORD_BYTES    = 4,
   parameter bit JOIN_ALIGNED  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_va,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [ADDR_W-1:0] pa,
   output logic              fault,
   output logic              fault_level,
   output logic [ADDR_W-1:0] fault_va,
   output logic [ADDR_W-1:0] fault_base
);

   localparam int WORD_SHIFT = $clog2(WORD_BYTES);
   localparam int L2_IDX_W   = SECT_SHIFT - SPAGE_SHIFT;

   generate
      if (!(ADDR_W > SECT_SHIFT && SECT_SHIFT > LPAGE_SHIFT && LPAGE_SHIFT > SPAGE_SHIFT))
         begin : g_chk_order
            $error("xlat_walker: mapping sizes must be ordered section > large > small");
         end
      if ((1 << WORD_SHIFT) != WORD_BYTES) begin : g_chk_word
         $error("xlat_walker: WORD_BYTES must be a power of two");
      end
      if (L2_IDX_W + WORD_SHIFT > L2_BASE_SHIFT) begin : g_chk_l2
         $error("xlat_walker: second-level table overruns its base alignment");
      end
      if (L2_BASE_SHIFT > SPAGE_SHIFT || WORD_SHIFT >= L2_BASE_SHIFT) begin : g_chk_base
         $error("xlat_walker: second-level base field out of range");
      end
   endgenerate

   ent_kind_e         l1_kind;
   ent_kind_e         l2_kind;
   ent_kind_e         pa_kind;
   logic [ADDR_W-1:0] l1_addr;
   logic [ADDR_W-1:0] l2_addr;
   logic [ADDR_W-1:0] pa_next;
   logic [ADDR_W-1:0] va_q;
   logic              second_level;

   xlat_entry_decode #(.LEVEL(1)) u_dec_l1 (
      .type_bits (mem_rsp_data[1:0]),
      .kind      (l1_kind)
   );

   xlat_entry_decode #(.LEVEL(2)) u_dec_l2 (
      .type_bits (mem_rsp_data[1:0]),
      .kind      (l2_kind)
   );

   xlat_addr_gen #(
      .ADDR_W        (ADDR_W),
      .SECT_SHIFT    (SECT_SHIFT),
      .SPAGE_SHIFT   (SPAGE_SHIFT),
      .L2_BASE_SHIFT (L2_BASE_SHIFT),
      .WORD_SHIFT    (WORD_SHIFT),
      .JOIN_ALIGNED  (JOIN_ALIGNED)
   ) u_addr (
      .tbl_base (tbl_base),
      .va_new   (req_va),
      .va_held  (va_q),
      .l1_entry (mem_rsp_data),
      .l1_addr  (l1_addr),
      .l2_addr  (l2_addr)
   );

   assign pa_kind = second_level ? l2_kind : l1_kind;

   xlat_pa_build #(
      .ADDR_W      (ADDR_W),
      .SECT_SHIFT  (SECT_SHIFT),
      .LPAGE_SHIFT (LPAGE_SHIFT),
      .SPAGE_SHIFT (SPAGE_SHIFT)
   ) u_pa (
      .kind   (pa_kind),
      .frame  (mem_rsp_data[ADDR_W-1:SPAGE_SHIFT]),
      .va_off (va_q[SECT_SHIFT-1:0]),
      .pa     (pa_next)
   );

   xlat_walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_va        (req_va),
      .tbl_base      (tbl_base),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .l1_kind       (l1_kind),
      .l2_kind       (l2_kind),
      .l1_addr       (l1_addr),
      .l2_addr       (l2_addr),
      .pa_next       (pa_next),
      .second_level  (second_level),
      .va_q          (va_q),
      .busy          (busy),
      .mem_req_valid (mem_req_valid),
      .mem_req_addr  (mem_req_addr),
      .done          (done),
      .pa            (pa),
      .fault         (fault),
      .fault_level   (fault_level),
      .fault_va      (fault_va),
      .fault_base    (fault_base)
   );

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
   parameter int ADDR_W     = 32,
   parameter int SECT_SHIFT = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_va,
   input logic              busy,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic [ADDR_W-1:0] mem_rsp_data,
   input logic              done,
   input logic [ADDR_W-1:0] pa,
   input logic              fault,
   input logic              fault_level,
   input logic [ADDR_W-1:0] fault_va
);

   logic [ADDR_W-1:0] va_seen;
   logic [ADDR_W-1:0] first_word;
   logic [1:0]        hs_n;
   logic [1:0]        rsp_n;
   logic              in_flight;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_seen    <= '0;
         first_word <= '0;
         hs_n       <= '0;
         rsp_n      <= '0;
         in_flight  <= 1'b0;
      end else begin
         if (req_valid && !busy) begin
            va_seen <= req_va;
            hs_n    <= '0;
            rsp_n   <= '0;
         end else begin
            if (mem_req_valid && mem_req_ready) hs_n <= hs_n + 2'd1;
            if (mem_rsp_valid && rsp_n != 2'd3) rsp_n <= rsp_n + 2'd1;
         end
         if (mem_rsp_valid && rsp_n == 2'd0) first_word <= mem_rsp_data;
         if (mem_req_valid && mem_req_ready) in_flight <= 1'b1;
         else if (mem_rsp_valid)             in_flight <= 1'b0;
      end
   end

   // R1: nothing is requested while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   // R2: the result strobe coincides with leaving the busy state
   a_r2_result_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fault) |-> !busy);

   // R2: a walk cannot end without a strobe
   a_r2_busy_ends_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_req_valid) ##1 !busy |-> (done || fault));

   // R10: result strobes are exclusive and one cycle long
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r10_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !fault);

   // R10: fault identity and level versus reads made
   a_r10_fault_va: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> fault_va == va_seen);
   a_r10_fault_level: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> fault_level == (rsp_n == 2'd2));

   // R5: a one-read success is a section built from the first word
   a_r5_section_pa: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_n == 2'd1) |->
         pa == {first_word[ADDR_W-1:SECT_SHIFT], va_seen[SECT_SHIFT-1:0]});

   // R11: request held under back-pressure
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R11: single outstanding read and at most two per walk
   a_r11_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !in_flight);
   a_r11_two_reads_max: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> hs_n < 2'd2);

endmodule

bind xlat_walker xlat_walker_chk #(
   .ADDR_W     (ADDR_W),
   .SECT_SHIFT (SECT_SHIFT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_va        (req_va),
   .busy          (busy),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_data  (mem_rsp_data),
   .done          (done),
   .pa            (pa),
   .fault         (fault),
   .fault_level   (fault_level),
   .fault_va      (fault_va)
);

// File: tb/xlat_walker_tb.sv
`timescale 1ns/1ps
module xlat_walker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tbl_base = 32'h0004_0000;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        busy;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done;
   logic [31:0] pa;
   logic        fault;
   logic        fault_level;
   logic [31:0] fault_va;
   logic [31:0] fault_base;

   always #4 clk = ~clk;

   xlat_walker u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tbl_base      (tbl_base),
      .req_valid     (req_valid),
      .req_va        (req_va),
      .busy          (busy),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .done          (done),
      .pa            (pa),
      .fault         (fault),
      .fault_level   (fault_level),
      .fault_va      (fault_va),
      .fault_base    (fault_base)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- memory image and model ----------------
   logic [31:0] mem [int unsigned];
   int          lat = 1;
   bit          stall_en = 1'b0;
   int          cnt = 0;
   logic [31:0] pend_addr = '0;
   int          rd_cnt = 0;
   logic [31:0] rd_last = '0;
   int unsigned cyc = 0;

   function automatic logic [31:0] rd(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rsp_valid <= 1'b0;
      if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= rd(pend_addr);
         end
      end
      if (req_valid && !busy) rd_cnt <= 0;
      if (mem_req_valid && mem_req_ready) begin
         pend_addr <= mem_req_addr;
         cnt       <= lat;
         rd_cnt    <= rd_cnt + 1;
         rd_last   <= mem_req_addr;
      end
      mem_req_ready <= stall_en ? (cyc % 3 == 2) : 1'b1;
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      bit          is_fault;
      logic [31:0] pa;
      logic [31:0] va;
      logic [31:0] base;
      bit          level;
      int          reads;
      logic [31:0] last_addr;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_results = 0;

   function automatic exp_t ref_walk(input logic [31:0] va, input logic [31:0] base, input string tag);
      exp_t e;
      logic [31:0] a1, e1, a2, e2;
      e.va = va; e.base = base; e.tag = tag; e.is_fault = 1'b0; e.level = 1'b0; e.pa = '0;
      a1 = base + {18'b0, va[31:20], 2'b00};               // R3
      e1 = rd(a1);
      e.reads = 1; e.last_addr = a1;
      if (e1[1:0] == 2'b10) begin                           // R4, R5
         e.pa = {e1[31:20], va[19:0]};
      end else if (e1[1:0] == 2'b01) begin
         a2 = {e1[31:10], 10'b0} + {22'b0, va[19:12], 2'b00}; // R6
         e2 = rd(a2);
         e.reads = 2; e.last_addr = a2;
         if (e2[1])      e.pa = {e2[31:12], va[11:0]};      // R7, R9
         else if (e2[0]) e.pa = {e2[31:16], va[15:0]};      // R8
         else begin e.is_fault = 1'b1; e.level = 1'b1; end  // R10
      end else begin
         e.is_fault = 1'b1; e.level = 1'b0;
      end
      return e;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && (done || fault)) begin
            n_results++;
            if (sb.size() == 0) begin
               chk(1'b0, "R2 unexpected result", pa, 32'h0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(!(done && fault), {"R10 exclusive ", e.tag}, {30'b0, done, fault}, 32'h0);
               chk(fault == e.is_fault, {"R4/R7 kind ", e.tag}, {31'b0, fault}, {31'b0, e.is_fault});
               if (e.is_fault) begin
                  chk(fault_va == e.va, {"R10 va ", e.tag}, fault_va, e.va);
                  chk(fault_base == e.base, {"R10 base ", e.tag}, fault_base, e.base);
                  chk(fault_level == e.level, {"R10 level ", e.tag}, {31'b0, fault_level}, {31'b0, e.level});
               end else begin
                  chk(pa == e.pa, {"R5/R8/R9 pa ", e.tag}, pa, e.pa);
               end
               chk(rd_cnt == e.reads, {"R11 reads ", e.tag}, rd_cnt, e.reads);
               chk(rd_last == e.last_addr, {"R3/R6 addr ", e.tag}, rd_last, e.last_addr);
            end
         end
      end
   end

   task automatic issue(input logic [31:0] va, input string tag);
      while (busy) @(negedge clk);
      sb.push_back(ref_walk(va, tbl_base, tag));
      req_va    = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, {"R2 busy after accept ", tag}, {31'b0, busy}, 32'h1);
   endtask

   task automatic drain();
      while (sb.size() != 0 || busy) @(negedge clk);
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=%h expected=%h", sb.size(), 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      // first-level table at 0x0004_0000
      mem[32'h0004_0004] = 32'h8AB0_0002;   // idx 0x001 section
      mem[32'h0004_000C] = 32'h1230_0003;   // idx 0x003 code 11 fault
      mem[32'h0004_0010] = 32'h0008_0401;   // idx 0x004 pointer, L2 at 0x0008_0400
      mem[32'h0004_3FFC] = 32'h0010_0002;   // idx 0xFFF section
      // second-level table at 0x0008_0400
      mem[32'h0008_0414] = 32'h7654_3002;   // idx 0x05 small
      mem[32'h0008_0418] = 32'h1111_1003;   // idx 0x06 small, code 11
      for (int i = 16; i < 32; i++) mem[32'h0008_0400 + 32'(i * 4)] = 32'hCAFE_0001; // large copies

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", {31'b0, busy}, 32'h0);
      chk(done == 1'b0, "R1 done", {31'b0, done}, 32'h0);
      chk(fault == 1'b0, "R1 fault", {31'b0, fault}, 32'h0);
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      issue(32'h0012_3456, "section");
      issue(32'hFFFF_FFFF, "section top index");
      issue(32'h0020_1000, "l1 fault 00");
      issue(32'h0030_0ABC, "l1 fault 11");
      issue(32'h0040_5ABC, "small");
      issue(32'h0040_6FFF, "small code 11");
      issue(32'h0040_7000, "l2 fault");
      issue(32'h0041_0000, "large first copy");
      issue(32'h0041_7123, "large mid copy");
      issue(32'h0041_FFFF, "large last copy");
      drain();

      // back-pressure and longer latency
      lat = 3; stall_en = 1'b1;
      issue(32'h0040_5001, "small stalled");
      issue(32'h0012_0000, "section stalled");
      issue(32'h0040_7FFF, "l2 fault stalled");
      drain();

      // R2: requests while busy are ignored; base captured at acceptance
      issue(32'h0041_8888, "large busy-ignore");
      req_va    = 32'h0012_FFFF;
      req_valid = 1'b1;
      tbl_base  = 32'h0000_0000;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      tbl_base  = 32'h0004_0000;
      drain();
      repeat (6) @(negedge clk);
      chk(n_results == 14, "R2 ignored while busy", n_results, 14);
      chk(sb.size() == 0, "R2 queue empty", sb.size(), 0);

      lat = 1; stall_en = 1'b0;
      issue(32'h0020_0000, "l1 fault after stall");
      drain();

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   end

endmodule